// File: doc/BRIEF.md
# Banked ROM-Overlay Chip-Select Decoder

This block is the combinational select logic of an 8-bit processor bus. From the upper address byte, the clock phase, the read/write line, two enables for the ROM windows and a bank-select line, it produces active-low selects for one RAM, one ROM and five I/O devices. It also drives the two upper ROM address bits. RAM is the floor of the whole 64 KB space. A ROM overlays two 8 KB windows, one at A000–BFFF and one at E000–FFFF. Each window can be switched off on its own, and the RAM underneath then becomes readable there. Writes aimed at a window always land in RAM.

I/O devices each take one 256-byte page, from DA00 to DE00. RAM is deselected on those pages, so they are the only RAM lost. RAM selection is qualified by the high clock phase. ROM and I/O selection depend on the address and control lines alone. The ROM holds four 8 KB banks. The bank line chooses which pair of banks is visible, and CPU address bit 14 picks the bank for each window.

Top module: `banked_rom_decoder`

## Requirements
- R1: `ram_sel_no` is 0 exactly when `phi2_i` is 1, the page is not an I/O page, and the ROM is not selected. Otherwise it is 1.
- R2: A read (`rd_nwr_i`=1) of page A0–BF with `rom_lo_en_i`=1 drives `rom_sel_no` to 0. This holds for either `phi2_i` level.
- R3: A read of page E0–FF with `rom_hi_en_i`=1 drives `rom_sel_no` to 0.
- R4: A write (`rd_nwr_i`=0) to either window keeps `rom_sel_no` at 1. RAM is then selected under R1.
- R5: A read of a window whose enable is 0 keeps `rom_sel_no` at 1, and RAM is selected under R1.
- R6: `io_sel_no[k]` is 0 exactly when the page equals DA+k, for k = 0..4 (0 and 1: the two parallel ports, 2: the serial port, 3: video, 4: audio). This does not depend on `phi2_i` or `rd_nwr_i`.
- R7: `rom_addr_hi_o[0]` equals CPU A14 (bit 6 of `addr_hi_i`). `rom_addr_hi_o[1]` equals `rom_bank_i`.
- R8: At most one of `ram_sel_no`, `rom_sel_no` and `io_sel_no` bits is 0 for any input combination.
- R9: Outside pages A0–BF and E0–FF, `rom_sel_no` stays 1 whatever the enables and the bank line are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr_hi_i | input | 8 | CPU address bits 15..8 (page number) |
| phi2_i | input | 1 | Clock phase, 1 = high phase |
| rd_nwr_i | input | 1 | 1 = read, 0 = write |
| rom_lo_en_i | input | 1 | Enables ROM reads in A000–BFFF |
| rom_hi_en_i | input | 1 | Enables ROM reads in E000–FFFF |
| rom_bank_i | input | 1 | Selects the visible pair of ROM banks |
| ram_sel_no | output | 1 | RAM select, active low |
| rom_sel_no | output | 1 | ROM select, active low |
| io_sel_no | output | 5 | I/O page selects, active low, bit k for page DA+k |
| rom_addr_hi_o | output | 2 | ROM A14 (bank) in bit 1, ROM A13 in bit 0 |

## Verification
Within a single access, the overlay decision and the RAM phase gate act together. A read of an enabled window during the high phase must choose ROM and drop RAM in the same combination. A write to the same page in the same phase must do the reverse. The bench sweeps every page against all 32 control states. Each state is a bit pattern over read/write, phase, both enables and the bank line. For every combination it compares each select against values derived arithmetically from page ranges, and it counts the active-low selects to confirm that no two devices are driven together.

// File: rtl/rom_ovl_pkg.sv
`timescale 1ns/1ps
package rom_ovl_pkg;
  localparam int PAGE_W   = 8;
  localparam int NUM_IO   = 5;
  localparam int NUM_WIN  = 2;
  localparam int TAG_W    = 3;
  localparam int BANK_W   = 2;
  localparam logic [PAGE_W-1:0] IO_BASE_PAGE = 8'hDA;
  // window w matches addr[15:13] == WIN_TAGS[w*TAG_W +: TAG_W]
  localparam logic [NUM_WIN*TAG_W-1:0] WIN_TAGS = {3'b111, 3'b101};
endpackage

// File: rtl/ovl_io_decode.sv
`timescale 1ns/1ps
module ovl_io_decode
  import rom_ovl_pkg::*;
(
  input  logic [PAGE_W-1:0] page_i,
  output logic [NUM_IO-1:0] io_sel_no,
  output logic              io_hit_o
);
  logic [NUM_IO-1:0] hit;

  for (genvar k = 0; k < NUM_IO; k++) begin : g_page
    localparam logic [PAGE_W-1:0] PG = IO_BASE_PAGE + PAGE_W'(k);
    assign hit[k] = (page_i == PG);
  end

  assign io_sel_no = ~hit;
  assign io_hit_o  = |hit;
endmodule

// File: rtl/ovl_rom_window.sv
`timescale 1ns/1ps
module ovl_rom_window
  import rom_ovl_pkg::*;
(
  input  logic [TAG_W-1:0]   tag_i,
  input  logic [NUM_WIN-1:0] en_i,
  input  logic               rd_i,
  output logic               rom_rd_o
);
  logic [NUM_WIN-1:0] live;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    assign live[w] = en_i[w] && (tag_i == WIN_TAGS[w*TAG_W +: TAG_W]);
  end

  // writes never reach the ROM; they fall to RAM below
  assign rom_rd_o = rd_i && (|live);
endmodule

// File: rtl/ovl_ram_gate.sv
`timescale 1ns/1ps
module ovl_ram_gate (
  input  logic phi2_i,
  input  logic io_hit_i,
  input  logic rom_rd_i,
  output logic ram_sel_no
);
  assign ram_sel_no = ~(phi2_i && !io_hit_i && !rom_rd_i);
endmodule

// File: rtl/banked_rom_decoder.sv
`timescale 1ns/1ps
module banked_rom_decoder
  import rom_ovl_pkg::*;
(
  input  logic [PAGE_W-1:0] addr_hi_i,
  input  logic              phi2_i,
  input  logic              rd_nwr_i,
  input  logic              rom_lo_en_i,
  input  logic              rom_hi_en_i,
  input  logic              rom_bank_i,
  output logic              ram_sel_no,
  output logic              rom_sel_no,
  output logic [NUM_IO-1:0] io_sel_no,
  output logic [BANK_W-1:0] rom_addr_hi_o
);
  logic io_hit;
  logic rom_rd;

  ovl_io_decode u_io (
    .page_i    (addr_hi_i),
    .io_sel_no (io_sel_no),
    .io_hit_o  (io_hit)
  );

  ovl_rom_window u_win (
    .tag_i    (addr_hi_i[PAGE_W-1 -: TAG_W]),
    .en_i     ({rom_hi_en_i, rom_lo_en_i}),
    .rd_i     (rd_nwr_i),
    .rom_rd_o (rom_rd)
  );

  ovl_ram_gate u_ram (
    .phi2_i     (phi2_i),
    .io_hit_i   (io_hit),
    .rom_rd_i   (rom_rd),
    .ram_sel_no (ram_sel_no)
  );

  // ROM select ignores the clock phase
  assign rom_sel_no    = ~rom_rd;
  // CPU A14 separates the two windows; bank line picks the 16 KB half
  assign rom_addr_hi_o = {rom_bank_i, addr_hi_i[PAGE_W-2]};
endmodule

// File: rtl/banked_rom_decoder_chk.sv
`timescale 1ns/1ps
module banked_rom_decoder_chk
  import rom_ovl_pkg::*;
(
  input logic [PAGE_W-1:0] addr_hi_i,
  input logic              phi2_i,
  input logic              rd_nwr_i,
  input logic              ram_sel_no,
  input logic              rom_sel_no,
  input logic [NUM_IO-1:0] io_sel_no
);
  logic in_win;
  logic io_page;
  assign in_win  = (addr_hi_i[7:5] == 3'b101) || (addr_hi_i[7:5] == 3'b111);
  assign io_page = (addr_hi_i >= IO_BASE_PAGE) &&
                   (addr_hi_i <  IO_BASE_PAGE + PAGE_W'(NUM_IO));

  always_comb begin
    p_one_sel_r8: assert ($onehot0(~{ram_sel_no, rom_sel_no, io_sel_no}));
    p_ram_phase_r1: assert (phi2_i || ram_sel_no);
    p_write_to_ram_r4: assert (rd_nwr_i || rom_sel_no);
    p_rom_outside_r9: assert (in_win || rom_sel_no);
    p_io_range_r6: assert (io_page || (&io_sel_no));
    p_ram_fill_r1: assert (!(phi2_i && !io_page && rom_sel_no) || !ram_sel_no);
  end
endmodule

bind banked_rom_decoder banked_rom_decoder_chk u_chk (
  .addr_hi_i  (addr_hi_i),
  .phi2_i     (phi2_i),
  .rd_nwr_i   (rd_nwr_i),
  .ram_sel_no (ram_sel_no),
  .rom_sel_no (rom_sel_no),
  .io_sel_no  (io_sel_no)
);

// File: tb/banked_rom_decoder_tb_top.sv
`timescale 1ns/1ps
module banked_rom_decoder_tb_top;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] addr_hi;
  logic       phi2, rd_nwr, en_lo, en_hi, bank;
  logic       ram_n, rom_n;
  logic [4:0] io_n;
  logic [1:0] rom_hi;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  banked_rom_decoder dut_i (
    .addr_hi_i     (addr_hi),
    .phi2_i        (phi2),
    .rd_nwr_i      (rd_nwr),
    .rom_lo_en_i   (en_lo),
    .rom_hi_en_i   (en_hi),
    .rom_bank_i    (bank),
    .ram_sel_no    (ram_n),
    .rom_sel_no    (rom_n),
    .io_sel_no     (io_n),
    .rom_addr_hi_o (rom_hi)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp, input int pg, input int cs);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s page=%02h ctl=%02h actual=%0h expected=%0h", tag, pg, cs, act, exp);
    end
  endtask

  initial begin
    addr_hi = 8'h00; phi2 = 0; rd_nwr = 1; en_lo = 0; en_hi = 0; bank = 0;
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk); #1;
    // idle state: phase low, page 00 read -> nothing selected
    chk(ram_n == 1'b1, "R1", ram_n, 1, 0, 0);
    chk(rom_n == 1'b1 && io_n == 5'h1f, "R9", {rom_n, io_n}, 6'h3f, 0, 0);

    for (int p = 0; p < 256; p++) begin
      for (int c = 0; c < 32; c++) begin
        bit in_lo, in_hi, rom_rd, io_any, exp_ram_n, exp_rom_n;
        int io_idx;
        logic [4:0] exp_io_n;
        logic [1:0] exp_hi;
        string rtag;
        @(negedge clk);
        addr_hi = 8'(p);
        rd_nwr = c[0]; phi2 = c[1]; en_lo = c[2]; en_hi = c[3]; bank = c[4];
        #1;
        in_lo  = (p >= 160) && (p < 192);
        in_hi  = (p >= 224);
        rom_rd = c[0] && ((in_lo && c[2]) || (in_hi && c[3]));
        io_idx = p - 218;
        io_any = (io_idx >= 0) && (io_idx < 5);
        exp_io_n = 5'h1f;
        if (io_any) exp_io_n[io_idx] = 1'b0;
        exp_rom_n = !rom_rd;
        exp_ram_n = !(c[1] && !io_any && !rom_rd);
        exp_hi = {c[4] != 0, ((p / 64) % 2) != 0};
        if (!(in_lo || in_hi)) rtag = "R9";
        else if (!c[0]) rtag = "R4";
        else if (!rom_rd) rtag = "R5";
        else if (in_lo) rtag = "R2";
        else rtag = "R3";
        chk(rom_n == exp_rom_n, rtag, rom_n, exp_rom_n, p, c);
        chk(ram_n == exp_ram_n, "R1", ram_n, exp_ram_n, p, c);
        chk(io_n == exp_io_n, "R6", io_n, exp_io_n, p, c);
        chk(rom_hi == exp_hi, "R7", rom_hi, exp_hi, p, c);
        chk($countones({~ram_n, ~rom_n, ~io_n}) <= 1, "R8",
            $countones({~ram_n, ~rom_n, ~io_n}), 1, p, c);
      end
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1600000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule